// File: doc/BRIEF.md
# Compare-Reset Timer Counter

The block is a 16-bit up-counter that runs from a clock-enable divider. Four compare channels each hold a 16-bit value. On every counting tick where the counter equals a channel's value, that channel's flag is raised. When the counter rolls from its top value to zero, an overflow flag is raised. A per-source enable mask combines the flags into one interrupt request. Software clears a flag by writing a one to its bit.

A modulus mode makes the highest channel, channel 3, the period register. On a tick where the counter equals that channel's value, the counter returns to zero instead of incrementing. Two boundary cases follow from this:
- A period value of zero holds the counter at zero.
- A period value of all ones gives a normal-looking rollover that does not count as an overflow.

All configuration goes through a small register port. It has one write strobe and a combinational read. The read needs no handshake and returns data in the same cycle. There is no back-pressure on this port. A write is always accepted on the clock edge where `wr_en` is high.

Top module: `cmp_timer`

Register map, at word addresses on `addr`:

| Address | Contents |
|---|---|
| 0–3 | Compare values for channels 0 to 3 |
| 4 | Control |
| 5 | Channel interrupt enables |
| 6 | Flags |
| 7 | Counter |

Control register fields:
- Bits [2:0] hold the prescale exponent N.
- Bit 3 turns on modulus mode.
- Bit 7 is the overflow interrupt enable.

Flags register fields:
- Bits [3:0] are the channel flags.
- Bit 4 is the overflow flag.

Any bit not named above reads as zero.

## Requirements
- R1: While reset is asserted, every register reads zero: the compare values, the control register, the enables, the flags and the counter. `irq`, `ch_flag` and `ovf_flag` are all low.
- R2: The counter advances by exactly one on each prescaler tick. A tick occurs once every 2^N clocks, where N is control bits [2:0]. Over a window of W clocks the counter advances by W/2^N.
- R3: With modulus mode off (control bit 3 = 0), a tick at count 0xFFFF gives a count of 0x0000 and sets the overflow flag (flags bit 4).
- R4: Channel i's flag (flags bit i) is set one clock after the tick on which the counter equals compare value i.
- R5: With modulus mode on, a tick at a count equal to the channel 3 compare value returns the counter to 0x0000. The count sequence then repeats with period (value + 1).
- R6: With modulus mode on and a channel 3 compare value of 0x0000, the counter stays at 0x0000.
- R7: With modulus mode on and a channel 3 compare value of 0xFFFF, the counter goes from 0xFFFF to 0x0000 and the overflow flag stays clear.
- R8: Writing address 6 clears each flag whose written bit is 1. Flags whose written bit is 0 are left unchanged. When a clear and a set fall on the same clock, the flag ends up set.
- R9: `irq` is high exactly when some channel flag is set together with its enable bit (address 5, bits [3:0]), or the overflow flag is set together with control bit 7.
- R10: The enables (address 5) and the control register (address 4) can be written at any time. They read back the written value in the defined bits and zero in all other bits.
- R11: Address 7 returns the live counter value. A write to address 7 has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Combinational read data |
| ch_flag | output | 4 | Channel compare flags |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can land on the same clock edge: a flag being set by a compare hit, and the same flag being cleared by a software write. The bench reads the counter and places the channel 2 compare value a known number of ticks ahead. It then times a write-one-to-clear of flag 2 so that the write lands on exactly the edge where the compare hits. The flag must read as set afterwards, and a later clear on a quiet edge must remove it. A similar collision comes from the modulus reset and the rollover at 0xFFFF sharing one tick. In that case the counter must read zero and the overflow flag must stay clear.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  // control register bit positions
  localparam int MOD_BIT  = 3;
  localparam int OVIE_BIT = 7;

  // bit mask of the low n bits of a divider
  function automatic logic [6:0] low_mask(input logic [2:0] n);
    logic [6:0] one;
    one = 7'd1;
    return (one << n) - 7'd1;
  endfunction
endpackage

// File: rtl/cmp_timer_prescale.sv
module cmp_timer_prescale #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  always_comb begin
    mask = '0;
    for (int b = 0; b < DIV_W; b++)
      if (b < int'(sel)) mask[b] = 1'b1;
  end

  assign tick = &(div_q | ~mask);

  // R2
  tick_full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> tick);
endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             mod_en,
  input  logic [CNT_W-1:0] top_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt
);
  logic [CNT_W-1:0] cnt_q;
  logic             match;
  logic             at_max;

  assign match  = mod_en && (cnt_q == top_val);
  assign at_max = &cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= match ? '0 : cnt_q + 1'b1;
  end

  assign cnt     = cnt_q;
  assign ovf_evt = tick && at_max && !match;

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  // R3
  free_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !mod_en && at_max) |=> (cnt_q == '0));
  // R5
  wrap_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mod_en && cnt_q == top_val) |=> (cnt_q == '0));
  // R6
  stay_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && top_val == '0 && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/cmp_timer_flags.sv
module cmp_timer_flags #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic [CNT_W-1:0]             cnt,
  input  logic [NUM_CH-1:0][CNT_W-1:0] cmp,
  input  logic                         ovf_evt,
  input  logic [NUM_CH-1:0]            clr_ch,
  input  logic                         clr_ovf,
  output logic [NUM_CH-1:0]            ch_flag,
  output logic                         ovf_flag
);
  logic [NUM_CH-1:0] hit;
  logic              ovf_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic flag_q;
    assign hit[i] = tick && (cnt == cmp[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q <= 1'b0;
      else if (hit[i])    flag_q <= 1'b1;
      else if (clr_ch[i]) flag_q <= 1'b0;
    end
    assign ch_flag[i] = flag_q;

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> ch_flag[i]);
    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ch[i] && !hit[i]) |=> !ch_flag[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_q <= 1'b0;
    else if (ovf_evt) ovf_q <= 1'b1;
    else if (clr_ovf) ovf_q <= 1'b0;
  end
  assign ovf_flag = ovf_q;

  // R3
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4,
  parameter int PRE_W  = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic [NUM_CH-1:0] ch_flag,
  output logic              ovf_flag,
  output logic              irq
);
  import cmp_timer_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NUM_CH);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(NUM_CH + 1);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(NUM_CH + 2);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(NUM_CH + 3);

  logic [NUM_CH-1:0][CNT_W-1:0] cmp_q;
  logic [PRE_W-1:0]             psc_q;
  logic                         mod_q;
  logic                         ovie_q;
  logic [NUM_CH-1:0]            ien_q;

  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             ovf_evt;
  logic             flag_wr;
  logic [NUM_CH-1:0] clr_ch;
  logic             clr_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      psc_q  <= '0;
      mod_q  <= 1'b0;
      ovie_q <= 1'b0;
      ien_q  <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_CH; i++)
        if (addr == ADDR_W'(i)) cmp_q[i] <= wdata;
      if (addr == A_CTRL) begin
        psc_q  <= wdata[PRE_W-1:0];
        mod_q  <= wdata[MOD_BIT];
        ovie_q <= wdata[OVIE_BIT];
      end
      if (addr == A_IEN) ien_q <= wdata[NUM_CH-1:0];
    end
  end

  assign flag_wr = wr_en && (addr == A_FLAG);
  assign clr_ch  = flag_wr ? wdata[NUM_CH-1:0] : '0;
  assign clr_ovf = flag_wr && wdata[NUM_CH];

  cmp_timer_prescale #(.PRE_W(PRE_W)) u_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (psc_q),
    .tick (tick)
  );

  cmp_timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .mod_en (mod_q),
    .top_val(cmp_q[NUM_CH-1]),
    .cnt    (cnt),
    .ovf_evt(ovf_evt)
  );

  cmp_timer_flags #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_flg (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .cnt     (cnt),
    .cmp     (cmp_q),
    .ovf_evt (ovf_evt),
    .clr_ch  (clr_ch),
    .clr_ovf (clr_ovf),
    .ch_flag (ch_flag),
    .ovf_flag(ovf_flag)
  );

  assign irq = (|(ch_flag & ien_q)) || (ovf_flag && ovie_q);

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (addr == ADDR_W'(i)) rdata = cmp_q[i];
    if (addr == A_CTRL) begin
      rdata[PRE_W-1:0] = psc_q;
      rdata[MOD_BIT]   = mod_q;
      rdata[OVIE_BIT]  = ovie_q;
    end
    if (addr == A_IEN) rdata[NUM_CH-1:0] = ien_q;
    if (addr == A_FLAG) begin
      rdata[NUM_CH-1:0] = ch_flag;
      rdata[NUM_CH]     = ovf_flag;
    end
    if (addr == A_CNT) rdata = cnt;
  end

  // R7
  no_ovf_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_q && (&cmp_q[NUM_CH-1])) |-> !ovf_evt);
  // R9
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_flag == '0 && !ovf_flag) |-> !irq);
  // R11
  cnt_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CNT && !tick) |=> $stable(cnt));
endmodule

// File: tb/test_cmp_timer.sv
module test_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  ch_flag;
  logic        ovf_flag;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  cmp_timer i_cmp_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ch_flag(ch_flag), .ovf_flag(ovf_flag), .irq(irq)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // called at a negedge; write lands on the next posedge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 reg", v, 0);
    end
    check("R1 irq", int'(irq), 0);
    check("R1 ch_flag", int'(ch_flag), 0);
    check("R1 ovf_flag", int'(ovf_flag), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_regs();
    int v, c1, c2;
    wr(3'd5, 16'hFFFF); rd(3'd5, v); check("R10 ien all", v, 16'h000F);
    wr(3'd5, 16'h0005); rd(3'd5, v); check("R10 ien 5", v, 16'h0005);
    wr(3'd4, 16'hFFFF); rd(3'd4, v); check("R10 ctrl", v, 16'h008F);
    wr(3'd4, 16'h0000); wr(3'd5, 16'h0000);
    rd(3'd7, c1);
    wr(3'd7, 16'hABCD);
    rd(3'd7, c2);
    check("R11 cnt write ignored", c2, c1 + 1);
  endtask

  task automatic t_prescale(input int n);
    int c1, c2;
    wr(3'd4, 16'(n));
    rd(3'd7, c1);
    repeat (64) @(negedge clk);
    rd(3'd7, c2);
    check($sformatf("R2 advance N=%0d", n), c2 - c1, 64 >> n);
  endtask

  task automatic t_compare();
    int c, v, k;
    wr(3'd6, 16'h001F);
    rd(3'd7, c);
    wr(3'd1, 16'(c + 40));
    rd(3'd7, c);
    k = 40 - 1;
    repeat (k) @(negedge clk);
    rd(3'd6, v); check("R4 flag1 before", (v >> 1) & 1, 0);
    @(negedge clk);
    rd(3'd6, v); check("R4 flag1 set", (v >> 1) & 1, 1);
    check("R4 ch_flag port", int'(ch_flag[1]), 1);
    check("R9 irq masked", int'(irq), 0);
    wr(3'd5, 16'h0002); check("R9 irq enabled", int'(irq), 1);
    wr(3'd5, 16'h0001); check("R9 irq other en", int'(irq), 0);
    wr(3'd6, 16'h0000); rd(3'd6, v); check("R8 write zero", (v >> 1) & 1, 1);
    wr(3'd6, 16'h001D); rd(3'd6, v); check("R8 other bits", (v >> 1) & 1, 1);
    wr(3'd6, 16'h0002); rd(3'd6, v); check("R8 clear", (v >> 1) & 1, 0);
    wr(3'd5, 16'h0000);
  endtask

  task automatic t_collide();
    int c, v, k;
    rd(3'd7, c);
    wr(3'd2, 16'(c + 30));
    rd(3'd7, v);
    k = c + 30 - v;
    repeat (k) @(negedge clk);
    wr(3'd6, 16'h0004);
    rd(3'd6, v); check("R8 set wins", (v >> 2) & 1, 1);
    wr(3'd6, 16'h0004);
    rd(3'd6, v); check("R8 clear later", (v >> 2) & 1, 0);
  endtask

  task automatic t_overflow();
    int c, v;
    wr(3'd4, 16'h0000);
    wr(3'd6, 16'h001F);
    rd(3'd7, c);
    repeat (16'hFFFF - c) @(negedge clk);
    rd(3'd7, v); check("R3 at max", v, 16'hFFFF);
    check("R3 no flag yet", int'(ovf_flag), 0);
    @(negedge clk);
    rd(3'd7, v); check("R3 wrapped", v, 0);
    rd(3'd6, v); check("R3 ovf flag", (v >> 4) & 1, 1);
    check("R9 ovf masked", int'(irq), 0);
    wr(3'd4, 16'h0080); check("R9 ovf irq", int'(irq), 1);
    wr(3'd4, 16'h0000); check("R9 ovf irq off", int'(irq), 0);
  endtask

  task automatic t_modulus();
    int c, v;
    wr(3'd3, 16'h0100);
    wr(3'd4, 16'h0008);
    rd(3'd7, c);
    repeat (16'h0100 - c) @(negedge clk);
    rd(3'd7, v); check("R5 at top", v, 16'h0100);
    @(negedge clk);
    rd(3'd7, v); check("R5 reset", v, 0);
    repeat (16'h0101) @(negedge clk);
    rd(3'd7, v); check("R5 period", v, 0);
    // R6: set period zero on the edge of a modulus reset
    rd(3'd7, c);
    repeat (16'h0100 - c) @(negedge clk);
    wr(3'd3, 16'h0000);
    rd(3'd7, v); check("R6 zero", v, 0);
    repeat (50) @(negedge clk);
    rd(3'd7, v); check("R6 held", v, 0);
  endtask

  task automatic t_mod_max();
    int c, v;
    wr(3'd3, 16'hFFFF);
    wr(3'd6, 16'h001F);
    rd(3'd7, c);
    repeat (16'hFFFF - c) @(negedge clk);
    rd(3'd7, v); check("R7 at max", v, 16'hFFFF);
    repeat (4) @(negedge clk);
    rd(3'd7, v); check("R7 wrapped", v, 3);
    rd(3'd6, v);
    check("R7 no ovf", (v >> 4) & 1, 0);
    check("R7 ch3 flag", (v >> 3) & 1, 1);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    @(negedge clk);
    t_regs();
    t_prescale(0);
    t_prescale(2);
    t_prescale(5);
    t_prescale(6);
    wr(3'd4, 16'h0000);
    t_compare();
    t_collide();
    t_overflow();
    t_modulus();
    t_mod_max();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule